// File: doc/BRIEF.md
# Hysteretic Clock-Lane Signal Detector

This block decides whether a usable clock signal is present on a differential receive lane. An analog peak detector, which is outside this block, measures the lane's peak-to-peak differential amplitude and delivers it as an unsigned millivolt sample with a one-cycle valid strobe. The block compares each valid sample against two thresholds, a higher one for asserting and a lower one for releasing, and keeps a single detect flag with hysteresis between them.

The two thresholds are picked by two independent 2-bit codes from fixed, non-monotonic lookup tables. The flag goes to an output pin and, as an identical copy, to a read-only status bit. The pin can be wired back to an enable input so the device drops into standby on its own when the clock disappears. Because of that loop, the detector has no enable or power-state input of its own: it evaluates every valid sample, in standby as well as in active operation.

Top module: `sd_hyst_det`

## Requirements
- R1: On a cycle with `amp_vld` high and `amp_mv` strictly greater than the selected assert level, the flag is high from the following clock edge on; an amplitude equal to the assert level does not set it.
- R2: On a cycle with `amp_vld` high and `amp_mv` strictly less than the selected release level (and not above the assert level), the flag is low from the following clock edge on; an amplitude equal to the release level does not clear it.
- R3: The assert level is chosen by `on_code`: 2'b00 = 70 mV, 2'b01 = 55 mV, 2'b10 = 90 mV, 2'b11 = 75 mV.
- R4: The release level is chosen by `off_code`: 2'b00 = 40 mV, 2'b01 = 30 mV, 2'b10 = 55 mV, 2'b11 = 45 mV.
- R5: A valid sample that is neither above the assert level nor below the release level leaves the flag unchanged.
- R6: While `amp_vld` is low the flag does not change, whatever `amp_mv` and the codes carry.
- R7: Each valid sample is judged against the codes present in the same cycle; a code change takes effect on the very next valid sample, with no stale level.
- R8: While `rst_n` is low, and at the first edge after its release, the flag is low.
- R9: `sig_det` and `stat_sd` carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_mv | input | AMP_W | Measured peak-to-peak differential amplitude in mV |
| amp_vld | input | 1 | High for one cycle per new amplitude sample |
| on_code | input | 2 | Assert-level select code |
| off_code | input | 2 | Release-level select code |
| sig_det | output | 1 | Signal-detect flag to the output pin |
| stat_sd | output | 1 | Signal-detect flag copy for the status register |

## Verification
The bench builds the block with AMP_W = 8, so that the full-scale sample of 255 mV is close at hand and every threshold of both tables sits well inside the range. This width lets the bench reach the exact boundary values (level, level plus one, level minus one) for all four codes of each table. It also lets the bench switch codes between two consecutive samples and hold the amplitude at full scale while the strobe is low.

// File: rtl/sd_hyst_pkg.sv
`timescale 1ns/1ps
package sd_hyst_pkg;

  // Width of the largest table entry (90 mV needs 7 bits)
  localparam int THR_W  = 7;
  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    SD_HOLD = 2'd0,
    SD_SET  = 2'd1,
    SD_CLR  = 2'd2
  } sd_act_e;

  // Assert level in mV for a given select code
  function automatic logic [THR_W-1:0] on_level_mv(input logic [CODE_W-1:0] code);
    logic [THR_W-1:0] lvl;
    case (code)
      2'b00:   lvl = THR_W'(70);
      2'b01:   lvl = THR_W'(55);
      2'b10:   lvl = THR_W'(90);
      default: lvl = THR_W'(75);
    endcase
    return lvl;
  endfunction

  // Release level in mV for a given select code
  function automatic logic [THR_W-1:0] off_level_mv(input logic [CODE_W-1:0] code);
    logic [THR_W-1:0] lvl;
    case (code)
      2'b00:   lvl = THR_W'(40);
      2'b01:   lvl = THR_W'(30);
      2'b10:   lvl = THR_W'(55);
      default: lvl = THR_W'(45);
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/sd_thr_lut.sv
`timescale 1ns/1ps
module sd_thr_lut
  import sd_hyst_pkg::*;
#(
  parameter int AMP_W = 10,
  parameter bit IS_ON = 1'b1
) (
  input  logic [CODE_W-1:0] code,
  output logic [AMP_W-1:0]  level_mv
);

  generate
    if (IS_ON) begin : g_on
      assign level_mv = AMP_W'(on_level_mv(code));
    end else begin : g_off
      assign level_mv = AMP_W'(off_level_mv(code));
    end
  endgenerate

endmodule

// File: rtl/sd_cmp.sv
`timescale 1ns/1ps
module sd_cmp
  import sd_hyst_pkg::*;
#(
  parameter int AMP_W = 10
) (
  input  logic [AMP_W-1:0] amp_mv,
  input  logic [AMP_W-1:0] on_lvl,
  input  logic [AMP_W-1:0] off_lvl,
  output logic             above_on,
  output logic             below_off,
  output sd_act_e          act
);

  assign above_on  = (amp_mv > on_lvl);
  assign below_off = (amp_mv < off_lvl);

  // Assert wins over release; neither means hold
  always_comb begin
    act = SD_HOLD;
    if (above_on) begin
      act = SD_SET;
    end else if (below_off) begin
      act = SD_CLR;
    end
  end

endmodule

// File: rtl/sd_flag.sv
`timescale 1ns/1ps
module sd_flag
  import sd_hyst_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    smp_vld,
  input  sd_act_e act,
  output logic    flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (smp_vld) begin
      case (act)
        SD_SET:  flag_q <= 1'b1;
        SD_CLR:  flag_q <= 1'b0;
        default: flag_q <= flag_q;
      endcase
    end
  end

endmodule

// File: rtl/sd_hyst_det.sv
`timescale 1ns/1ps
module sd_hyst_det
  import sd_hyst_pkg::*;
#(
  parameter int AMP_W = 10   // must be at least THR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AMP_W-1:0]  amp_mv,
  input  logic              amp_vld,
  input  logic [1:0]        on_code,
  input  logic [1:0]        off_code,
  output logic              sig_det,
  output logic              stat_sd
);

  // Named internal events, brought out for the checker
  logic [AMP_W-1:0] on_lvl;
  logic [AMP_W-1:0] off_lvl;
  logic             above_on;
  logic             below_off;
  sd_act_e          act;
  logic             flag_q;

  sd_thr_lut #(.AMP_W(AMP_W), .IS_ON(1'b1)) u_on_lut (
    .code     (on_code),
    .level_mv (on_lvl)
  );

  sd_thr_lut #(.AMP_W(AMP_W), .IS_ON(1'b0)) u_off_lut (
    .code     (off_code),
    .level_mv (off_lvl)
  );

  sd_cmp #(.AMP_W(AMP_W)) u_cmp (
    .amp_mv    (amp_mv),
    .on_lvl    (on_lvl),
    .off_lvl   (off_lvl),
    .above_on  (above_on),
    .below_off (below_off),
    .act       (act)
  );

  sd_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (amp_vld),
    .act     (act),
    .flag_q  (flag_q)
  );

  assign sig_det = flag_q;
  assign stat_sd = flag_q;

endmodule

// File: rtl/sd_hyst_det_chk.sv
`timescale 1ns/1ps
module sd_hyst_det_chk #(
  parameter int AMP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AMP_W-1:0] amp_mv,
  input logic             amp_vld,
  input logic [1:0]       on_code,
  input logic [1:0]       off_code,
  input logic             sig_det,
  input logic             stat_sd,
  input logic             above_on,
  input logic             below_off
);

  localparam logic [AMP_W-1:0] MV90 = AMP_W'(90);
  localparam logic [AMP_W-1:0] MV30 = AMP_W'(30);

  a_r1_set_on_above: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_vld && above_on) |=> sig_det);

  a_r2_clear_on_below: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_vld && below_off && !above_on) |=> !sig_det);

  // R3: highest assert code, amplitude above 90 mV must set
  a_r3_top_code_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_vld && on_code == 2'b10 && amp_mv > MV90) |=> sig_det);

  // R4: lowest release code, amplitude below 30 mV must clear
  a_r4_low_code_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_vld && off_code == 2'b01 && amp_mv < MV30) |=> !sig_det);

  a_r5_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_vld && !above_on && !below_off) |=> $stable(sig_det));

  a_r6_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_vld |=> $stable(sig_det));

  a_r8_reset_low: assert property (@(posedge clk)
    !rst_n |=> !sig_det);

  a_r9_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
    sig_det == stat_sd);

endmodule

bind sd_hyst_det sd_hyst_det_chk #(.AMP_W(AMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .amp_mv    (amp_mv),
  .amp_vld   (amp_vld),
  .on_code   (on_code),
  .off_code  (off_code),
  .sig_det   (sig_det),
  .stat_sd   (stat_sd),
  .above_on  (above_on),
  .below_off (below_off)
);

// File: tb/sd_hyst_det_tb.sv
`timescale 1ns/1ps
module sd_hyst_det_tb;

  localparam int AMP_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [AMP_W-1:0] amp_mv = '0;
  logic             amp_vld = 1'b0;
  logic [1:0]       on_code = 2'b00;
  logic [1:0]       off_code = 2'b00;
  logic             sig_det;
  logic             stat_sd;

  always #4 clk = ~clk;   // 125 MHz

  sd_hyst_det #(.AMP_W(AMP_W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .amp_mv   (amp_mv),
    .amp_vld  (amp_vld),
    .on_code  (on_code),
    .off_code (off_code),
    .sig_det  (sig_det),
    .stat_sd  (stat_sd)
  );

  int    n_run  = 0;
  int    n_fail = 0;
  bit    q_exp[$];
  string q_tag[$];
  bit    model  = 1'b0;
  int    set_mv[4] = '{70, 55, 90, 75};
  int    rel_mv[4] = '{40, 30, 55, 45};

  // Driver: applies one sample cycle and queues the flag expected after it
  task automatic step(input int amp, input bit vld, input int onc, input int offc,
                      input string tag);
    @(negedge clk);
    amp_mv   = AMP_W'(amp);
    amp_vld  = vld;
    on_code  = 2'(onc);
    off_code = 2'(offc);
    if (vld) begin
      if (amp > set_mv[onc])      model = 1'b1;
      else if (amp < rel_mv[offc]) model = 1'b0;
    end
    q_exp.push_back(model);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        bit    e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_run++;
        if (sig_det !== e) begin
          n_fail++;
          $display("FAIL %s: sig_det actual=%b expected=%b", t, sig_det, e);
        end
        n_run++;
        if (stat_sd !== e) begin
          n_fail++;
          $display("FAIL R9 (%s): stat_sd actual=%b expected=%b", t, stat_sd, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 1'b0, 0, 0, "R8 reset low");
    step(70, 1'b1, 0, 0, "R1 equal to 70 does not set");
    step(71, 1'b1, 0, 0, "R1 71 above 70 sets");
    step(0, 1'b0, 0, 0, "R6 no strobe keeps high");
    step(40, 1'b1, 0, 0, "R2 equal to 40 does not clear");
    step(55, 1'b1, 0, 0, "R5 in band holds high");
    step(39, 1'b1, 0, 0, "R2 39 below 40 clears");
    step(70, 1'b1, 0, 0, "R5 in band holds low");
    step(255, 1'b0, 0, 0, "R6 no strobe keeps low at full scale");
    // Assert table, every code
    for (int c = 0; c < 4; c++) begin
      step(0, 1'b1, c, 1, "R2 clear before code test");
      step(set_mv[c], 1'b1, c, 1, "R3 level itself does not set");
      step(set_mv[c] + 1, 1'b1, c, 1, "R3 level plus one sets");
    end
    // Release table, every code
    for (int c = 0; c < 4; c++) begin
      step(255, 1'b1, 0, c, "R1 full scale sets");
      step(rel_mv[c], 1'b1, 0, c, "R4 level itself does not clear");
      step(rel_mv[c] - 1, 1'b1, 0, c, "R4 level minus one clears");
    end
    // Code change takes effect on the next sample
    step(80, 1'b1, 2, 0, "R7 80 under 90 stays low");
    step(80, 1'b1, 3, 0, "R7 switch to 75 sets at once");
    step(50, 1'b1, 0, 0, "R7 50 above 40 holds high");
    step(50, 1'b1, 0, 2, "R7 switch release to 55 clears at once");
    step(56, 1'b1, 1, 2, "R7 56 above 55 sets with new assert code");
    step(255, 1'b0, 0, 0, "R6 idle holds high");
    @(negedge clk);
    amp_vld = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule